// File: doc/BRIEF.md
# Overcurrent Circuit Breaker Timer

This block is the digital decision stage of a hot-swap gate driver. Two analog comparators watch the voltage across the current-sense resistor. One reports that the voltage is above a fixed low level of 50 mV. The other reports that it is above a selectable quick-trip level. From these two flags the block decides whether the pass transistor's gate stays enabled. A severe overcurrent opens the breaker on the next clock edge. A moderate overcurrent opens it only if the condition persists, unbroken, for a programmed window, so that short spikes do not cause spurious shutdowns.

The quick-trip level is chosen by a 2-bit select and sent back to the analog side as a registered code. The same select can switch the quick path off, which leaves only the filtered path active. The slow-path window is chosen by a second 2-bit select. Window lengths in cycles are computed from the parameter `CLK_KHZ` as `us * CLK_KHZ / 1000`, with a floor of 2 cycles. Once the breaker opens it stays open until a restart request or a reset.

The controller has three states:
- `ST_ARMED`: the gate is on and no overcurrent is seen.
- `ST_FILTER`: the gate is on and the slow-path window is being timed.
- `ST_TRIPPED`: the gate is off and the trip flag is set.

Transitions:
- ARMED→FILTER on a low-level flag.
- FILTER→ARMED when the low-level flag drops.
- ARMED→TRIPPED or FILTER→TRIPPED on a live quick-trip hit.
- FILTER→TRIPPED when the window expires.
- TRIPPED→ARMED on a restart request.

Top module: `cb_trip_timer`

## Requirements
- R1: While reset is asserted and after it is released with no overcurrent, `gate_en_o` is 1, `tripped_o` is 0 and `qt_code_o` is 2'b00.
- R2: With the quick path off, `sense_lo_i` sampled high on N consecutive rising edges turns the gate off and sets `tripped_o` at the N-th edge, and not before. N is 5, 50, 150 or 400 us of clock for `dly_sel_i` = 00, 01, 10 or 11 respectively, and is never below 2 cycles.
- R3: When `qt_sel_i` is not 2'b11 and `sense_qt_i` is sampled high in a non-tripped state, the gate turns off and `tripped_o` sets at that same edge.
- R4: When `qt_sel_i` is 2'b11 the quick path is off and `sense_qt_i` has no effect on the outputs; any excess is handled only by the slow path of R2.
- R5: If `sense_lo_i` is sampled low before the window completes, the elapsed time is discarded, and a later excess needs a full N further consecutive edges to trip.
- R6: Once tripped, `gate_en_o` stays 0 and `tripped_o` stays 1 until `restart_i` is sampled high, which returns the block to ARMED with a cleared window at that edge. A restart while not tripped has no effect, and the window in progress keeps counting.
- R7: `qt_code_o` carries the value of `qt_sel_i` sampled at the previous rising edge. The encoding is 00 = 200 mV, 01 = 100 mV, 10 = 60 mV and 11 = off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sense_lo_i | input | 1 | Sense voltage above the fixed 50 mV level |
| sense_qt_i | input | 1 | Sense voltage above the selected quick-trip level |
| qt_sel_i | input | 2 | Quick-trip level select (00 = 200 mV, 01 = 100 mV, 10 = 60 mV, 11 = off) |
| dly_sel_i | input | 2 | Slow-trip window select (00 = 5 us, 01 = 50 us, 10 = 150 us, 11 = 400 us) |
| restart_i | input | 1 | Request to close the breaker again after a trip |
| gate_en_o | output | 1 | Gate drive enable, 1 = pass transistor on |
| tripped_o | output | 1 | Breaker has opened |
| qt_code_o | output | 2 | Registered quick-trip level code for the analog comparator |

## Verification
A wrong state or a stray count shows at the gate enable, because the timing of every trip is exact to the cycle. A window counter that was not cleared after a dip, or that started one count off, moves the trip edge away from the N-th consecutive high sample. Sampling every cycle exposes that error on the first affected trip. A state that is lost while tripped shows as the gate coming back without a restart within one cycle. A quick-trip decode that is wrong shows at the edge after the first hit, as either a missed trip or a spurious one.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

    typedef enum logic [1:0] {
        ST_ARMED   = 2'd0,
        ST_FILTER  = 2'd1,
        ST_TRIPPED = 2'd2
    } cbt_state_t;

    localparam logic [1:0] QT_OFF = 2'b11;

    // Slow-path window in microseconds for a delay select index
    function automatic int unsigned window_us(input int unsigned idx);
        case (idx)
            0:       return 5;
            1:       return 50;
            2:       return 150;
            default: return 400;
        endcase
    endfunction

    // Window length in clock cycles, never below two
    function automatic int unsigned window_cycles(input int unsigned idx,
                                                  input int unsigned clk_khz);
        int unsigned c;
        c = (window_us(idx) * clk_khz) / 1000;
        if (c < 2) c = 2;
        return c;
    endfunction

endpackage

// File: rtl/cbt_delay_sel.sv
module cbt_delay_sel #(
    parameter int unsigned CLK_KHZ = 100000,
    parameter int unsigned CW      = 16
) (
    input  logic [1:0]    sel_i,
    output logic [CW-1:0] limit_m1_o
);
    import cbt_pkg::*;

    localparam int unsigned NSEL = 4;

    logic [CW-1:0] lim_tab [NSEL];

    for (genvar g = 0; g < NSEL; g++) begin : g_lim
        localparam int unsigned CYC = window_cycles(g, CLK_KHZ);
        assign lim_tab[g] = CW'(CYC - 1);
    end

    assign limit_m1_o = lim_tab[sel_i];

endmodule

// File: rtl/cbt_window_ctr.sv
module cbt_window_ctr #(
    parameter int unsigned CW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          run_i,
    input  logic [CW-1:0] limit_m1_i,
    output logic          expire_o
);
    logic [CW-1:0] run_cnt_q;

    // Expiry fires on the sample that completes the window
    assign expire_o = run_i && (run_cnt_q >= limit_m1_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            run_cnt_q <= '0;
        end else if (!run_i || expire_o) begin
            run_cnt_q <= '0;
        end else begin
            run_cnt_q <= run_cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/cbt_qt_decode.sv
module cbt_qt_decode (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] sel_i,
    input  logic       hit_i,
    output logic       fire_o,
    output logic [1:0] code_o
);
    import cbt_pkg::*;

    assign fire_o = hit_i && (sel_i != QT_OFF);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            code_o <= 2'b00;
        end else begin
            code_o <= sel_i;
        end
    end

endmodule

// File: rtl/cb_trip_timer.sv
module cb_trip_timer #(
    parameter int unsigned CLK_KHZ = 100000
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       sense_lo_i,
    input  logic       sense_qt_i,
    input  logic [1:0] qt_sel_i,
    input  logic [1:0] dly_sel_i,
    input  logic       restart_i,
    output logic       gate_en_o,
    output logic       tripped_o,
    output logic [1:0] qt_code_o
);
    import cbt_pkg::*;

    localparam int unsigned MAX_CYC = window_cycles(3, CLK_KHZ);
    localparam int unsigned CW      = $clog2(MAX_CYC + 1);

    cbt_state_t    state_q, state_d;
    logic [CW-1:0] limit_m1;
    logic          win_run;
    logic          win_expire;
    logic          qt_fire;

    cbt_delay_sel #(.CLK_KHZ(CLK_KHZ), .CW(CW)) u_dsel (
        .sel_i      (dly_sel_i),
        .limit_m1_o (limit_m1)
    );

    assign win_run = sense_lo_i && (state_q != ST_TRIPPED);

    cbt_window_ctr #(.CW(CW)) u_wctr (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (win_run),
        .limit_m1_i (limit_m1),
        .expire_o   (win_expire)
    );

    cbt_qt_decode u_qdec (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sel_i  (qt_sel_i),
        .hit_i  (sense_qt_i),
        .fire_o (qt_fire),
        .code_o (qt_code_o)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: begin
                if (qt_fire || win_expire) state_d = ST_TRIPPED;
                else if (sense_lo_i)       state_d = ST_FILTER;
            end
            ST_FILTER: begin
                if (qt_fire || win_expire) state_d = ST_TRIPPED;
                else if (!sense_lo_i)      state_d = ST_ARMED;
            end
            ST_TRIPPED: begin
                if (restart_i) state_d = ST_ARMED;
            end
            default: state_d = ST_TRIPPED;
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_ARMED;
        else         state_q <= state_d;
    end

    // Outputs
    always_comb begin
        gate_en_o = 1'b1;
        tripped_o = 1'b0;
        unique case (state_q)
            ST_ARMED, ST_FILTER: begin
                gate_en_o = 1'b1;
                tripped_o = 1'b0;
            end
            ST_TRIPPED: begin
                gate_en_o = 1'b0;
                tripped_o = 1'b1;
            end
            default: begin
                gate_en_o = 1'b0;
                tripped_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/cbt_checker.sv
module cbt_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sense_lo,
    input logic       sense_qt,
    input logic [1:0] qt_sel,
    input logic       restart,
    input logic       gate_en,
    input logic       tripped,
    input logic [1:0] qt_code
);

    AST_RESET_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (gate_en && !tripped && qt_code == 2'b00)); // R1

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!tripped && !sense_lo && !(sense_qt && qt_sel != 2'b11)) |=> gate_en); // R2

    AST_QUICK_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (!tripped && sense_qt && qt_sel != 2'b11) |=> (tripped && !gate_en)); // R3

    AST_QT_OFF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!tripped && qt_sel == 2'b11 && !sense_lo) |=> !tripped); // R4

    AST_TRIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (tripped && !restart) |=> (tripped && !gate_en)); // R6

    AST_RESTART_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (tripped && restart) |=> (gate_en && !tripped)); // R6

    AST_CODE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (qt_code == $past(qt_sel))); // R7

endmodule

bind cb_trip_timer cbt_checker u_chk (
    .clk      (clk_i),
    .rst_n    (rst_ni),
    .sense_lo (sense_lo_i),
    .sense_qt (sense_qt_i),
    .qt_sel   (qt_sel_i),
    .restart  (restart_i),
    .gate_en  (gate_en_o),
    .tripped  (tripped_o),
    .qt_code  (qt_code_o)
);

// File: tb/cb_trip_timer_tb.sv
`timescale 1ns/1ps
module cb_trip_timer_tb;

    localparam int unsigned CLK_KHZ = 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lo = 1'b0;
    logic       qt = 1'b0;
    logic [1:0] qsel = 2'b11;
    logic [1:0] dsel = 2'b00;
    logic       rst_req = 1'b0;
    logic       gate_en;
    logic       tripped;
    logic [1:0] qcode;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    bit         m_trip = 1'b0;
    int         m_run = 0;
    logic [1:0] m_code = 2'b00;

    always #2 clk = ~clk;

    cb_trip_timer #(.CLK_KHZ(CLK_KHZ)) u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .sense_lo_i (lo),
        .sense_qt_i (qt),
        .qt_sel_i   (qsel),
        .dly_sel_i  (dsel),
        .restart_i  (rst_req),
        .gate_en_o  (gate_en),
        .tripped_o  (tripped),
        .qt_code_o  (qcode)
    );

    function automatic int win_n(input logic [1:0] d);
        int us;
        int c;
        case (d)
            2'b00:   us = 5;
            2'b01:   us = 50;
            2'b10:   us = 150;
            default: us = 400;
        endcase
        c = us * int'(CLK_KHZ) / 1000;
        return (c < 2) ? 2 : c;
    endfunction

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp_v,
                         input string what);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp_v, $time);
        end
    endtask

    // Advance one clock with the current inputs; update model, compare outputs
    task automatic step(input string tag);
        if (m_trip) begin
            if (rst_req) m_trip = 1'b0;
            m_run = 0;
        end else if (qt && qsel != 2'b11) begin
            m_trip = 1'b1;
            m_run  = 0;
        end else if (lo) begin
            m_run++;
            if (m_run >= win_n(dsel)) begin
                m_trip = 1'b1;
                m_run  = 0;
            end
        end else begin
            m_run = 0;
        end
        m_code = qsel;
        @(posedge clk);
        @(negedge clk);
        check(tag, {1'b0, gate_en}, {1'b0, ~m_trip}, "gate_en");
        check(tag, {1'b0, tripped}, {1'b0, m_trip}, "tripped");
        check("R7", qcode, m_code, "qt_code");
    endtask

    task automatic idle(input int n, input string tag);
        lo = 0; qt = 0; rst_req = 0;
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic do_restart(input string tag);
        lo = 0; qt = 0; rst_req = 1;
        step(tag);
        rst_req = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20251));
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1", {1'b0, gate_en}, 2'd1, "gate_en in reset");
        check("R1", {1'b0, tripped}, 2'd0, "tripped in reset");
        check("R1", qcode, 2'b00, "qt_code in reset");
        rst_n = 1'b1;
        m_code = 2'b00;
        qsel = 2'b00;
        idle(3, "R1");

        // R2 full window for each delay select, quick path off
        qsel = 2'b11;
        for (int d = 0; d < 4; d++) begin
            dsel = 2'(d);
            lo = 1;
            for (int i = 0; i < win_n(dsel) + 3; i++) step("R2");
            do_restart("R6");
            idle(2, "R2");
        end

        // R5 a dip discards the elapsed time
        dsel = 2'b01;
        lo = 1;
        for (int i = 0; i < win_n(dsel) - 1; i++) step("R5");
        lo = 0; step("R5");
        lo = 1;
        for (int i = 0; i < win_n(dsel) - 1; i++) step("R5");
        check("R5", {1'b0, gate_en}, 2'd1, "gate after interrupted windows");
        step("R5");
        check("R5", {1'b0, tripped}, 2'd1, "trip after full fresh window");
        do_restart("R6");

        // R3 quick trip at each enabled level
        for (int s = 0; s < 3; s++) begin
            qsel = 2'(s);
            lo = 1; qt = 0; step("R3");
            qt = 1; step("R3");
            check("R3", {1'b0, gate_en}, 2'd0, "gate after quick hit");
            qt = 0; lo = 0;
            idle(3, "R6");
            do_restart("R6");
        end

        // R4 quick path off ignores the quick flag
        qsel = 2'b11; dsel = 2'b00;
        lo = 0; qt = 1;
        for (int i = 0; i < 20; i++) step("R4");
        check("R4", {1'b0, gate_en}, 2'd1, "gate with quick path off");
        lo = 1;
        for (int i = 0; i < win_n(dsel); i++) step("R4");
        qt = 0;
        do_restart("R6");

        // R6 restart while armed leaves the running window alone
        dsel = 2'b01; lo = 1;
        for (int i = 0; i < 10; i++) step("R6");
        rst_req = 1; step("R6"); rst_req = 0;
        for (int i = 0; i < win_n(dsel) - 11; i++) step("R6");
        check("R6", {1'b0, tripped}, 2'd1, "trip despite armed restart");
        lo = 0; idle(30, "R6");
        do_restart("R6");

        // Constrained random mix
        qsel = 2'b11; dsel = 2'b00; lo = 0;
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(63) == 0) lo = ~lo;
            qt = ($urandom_range(79) == 0);
            rst_req = ($urandom_range(24) == 0);
            if ($urandom_range(299) == 0) dsel = 2'($urandom_range(2));
            if ($urandom_range(199) == 0) qsel = 2'($urandom_range(3));
            step(qt ? "R3" : "R2");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule